// File: doc/BRIEF.md
# Indirect RAM Window Port

This block places a byte-wide RAM behind two locations of a small register bus. One location is a pointer register that selects a RAM byte; the other is a data window through which that byte is read or written. A host that sees only a few register addresses can therefore reach every byte of a much larger memory. The depth of the memory is set by the pointer width; the default is 256 bytes behind an 8-bit pointer.

The bus is synchronous. Each clock cycle in which chip select and a strobe are high is exactly one access. Writes take effect at that clock edge. Read data is registered and appears on `rdata_o` one cycle after the read strobe, then holds until the next read.

With the burst input high, every data-window access moves the pointer on by one after the access, so a block of bytes can be streamed by hitting the window repeatedly. The pointer wraps from its top value to zero. With burst low, the window keeps hitting the same byte.

Top module: `ram_window_port`

## Requirements
- R1: While `rst_ni` is low and after its release, the pointer is 00h and `rdata_o` is 00h until the first read.
- R2: A write to offset 10h loads the pointer from `wdata_i[7:0]`; a read of offset 10h puts the pointer value on `rdata_o` in the next cycle.
- R3: A write to offset 13h stores `wdata_i` in the RAM byte the pointer selects; a read of offset 13h puts that byte on `rdata_o` in the next cycle.
- R4: With `burst_en_i` low, data-window accesses leave the pointer unchanged, so repeated accesses reach the same byte.
- R5: With `burst_en_i` high, the pointer rises by one after each read or write of offset 13h; a read returns the byte selected before that increment.
- R6: Accesses to any offset other than 13h never increment the pointer; reads of offsets other than 10h and 13h return 00h, and writes to them change neither pointer nor RAM.
- R7: The pointer wraps from FFh to 00h on a burst increment.
- R8: With `cs_i` low nothing changes; with `rd_i` and `wr_i` both high, only the write is performed and `rdata_o` holds.
- R9: A pointer write in the cycle right after a burst data access leaves the pointer at the written value, not at that value plus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Chip select, active high |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| addr_i | input | 5 | Register offset |
| wdata_i | input | 8 | Write data |
| burst_en_i | input | 1 | Pointer auto-increment after data-window accesses |
| rdata_o | output | 8 | Registered read data |

## Verification
Writes to the pointer or the RAM are visible at the clock edge that samples the strobe, and read data lands on `rdata_o` one edge later; the bench drives each access just after a falling edge, lets one rising edge pass, and compares `rdata_o` against its model at the following falling edge. The pointer, being internal, is observed by reading offset 10h one cycle after any access that could move it, so both increments and non-increments are seen at the port. Wrap, load-after-burst, dual strobes and deselected cycles are driven as directed cases around a long random run.

// File: rtl/ram_window_pkg.sv
package ram_window_pkg;

  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_PTR_WR,
    ACC_PTR_RD,
    ACC_DAT_WR,
    ACC_DAT_RD,
    ACC_OTH_WR,
    ACC_OTH_RD
  } acc_kind_e;

  function automatic logic is_data_acc(acc_kind_e k);
    return (k == ACC_DAT_WR) || (k == ACC_DAT_RD);
  endfunction

endpackage

// File: rtl/ram_window_decode.sv
module ram_window_decode
  import ram_window_pkg::*;
#(
  parameter int          AW       = 5,
  parameter logic [AW-1:0] PTR_OFS = 5'h10,
  parameter logic [AW-1:0] DAT_OFS = 5'h13
) (
  input  logic          cs_i,
  input  logic          rd_i,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  output acc_kind_e     kind_o
);

  // write wins over read when both strobes are high
  always_comb begin
    kind_o = ACC_NONE;
    if (cs_i && wr_i) begin
      if (addr_i == PTR_OFS)      kind_o = ACC_PTR_WR;
      else if (addr_i == DAT_OFS) kind_o = ACC_DAT_WR;
      else                        kind_o = ACC_OTH_WR;
    end else if (cs_i && rd_i) begin
      if (addr_i == PTR_OFS)      kind_o = ACC_PTR_RD;
      else if (addr_i == DAT_OFS) kind_o = ACC_DAT_RD;
      else                        kind_o = ACC_OTH_RD;
    end
  end

endmodule

// File: rtl/ram_window_ptr.sv
module ram_window_ptr #(
  parameter int PW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [PW-1:0] load_val_i,
  input  logic          inc_i,
  output logic [PW-1:0] ptr_o
);

  logic [PW-1:0] ptr_q, ptr_d;

  // load has priority; increment wraps naturally at PW bits
  always_comb begin
    ptr_d = ptr_q;
    if (load_i)     ptr_d = load_val_i;
    else if (inc_i) ptr_d = ptr_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else         ptr_q <= ptr_d;
  end

  assign ptr_o = ptr_q;

endmodule

// File: rtl/ram_window_mem.sv
module ram_window_mem #(
  parameter int PW = 8,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [PW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);

  localparam int Depth = 1 << PW;

  logic [DW-1:0] mem_q [Depth];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[addr_i];

endmodule

// File: rtl/ram_window_port.sv
module ram_window_port
  import ram_window_pkg::*;
#(
  parameter int            AW      = 5,
  parameter int            DW      = 8,
  parameter int            PW      = 8,
  parameter logic [AW-1:0] PTR_OFS = 5'h10,
  parameter logic [AW-1:0] DAT_OFS = 5'h13
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_i,
  input  logic          rd_i,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          burst_en_i,
  output logic [DW-1:0] rdata_o
);

  acc_kind_e     kind;
  logic [PW-1:0] ptr_q;
  logic [DW-1:0] mem_rdata;
  logic [DW-1:0] rdata_q, rdata_d;
  logic          rd_hit;

  ram_window_decode #(
    .AW      (AW),
    .PTR_OFS (PTR_OFS),
    .DAT_OFS (DAT_OFS)
  ) u_decode (
    .cs_i   (cs_i),
    .rd_i   (rd_i),
    .wr_i   (wr_i),
    .addr_i (addr_i),
    .kind_o (kind)
  );

  ram_window_ptr #(
    .PW (PW)
  ) u_ptr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (kind == ACC_PTR_WR),
    .load_val_i (wdata_i[PW-1:0]),
    .inc_i      (burst_en_i && is_data_acc(kind)),
    .ptr_o      (ptr_q)
  );

  ram_window_mem #(
    .PW (PW),
    .DW (DW)
  ) u_mem (
    .clk_i   (clk_i),
    .we_i    (kind == ACC_DAT_WR),
    .addr_i  (ptr_q),
    .wdata_i (wdata_i),
    .rdata_o (mem_rdata)
  );

  assign rd_hit = (kind == ACC_PTR_RD) || (kind == ACC_DAT_RD) || (kind == ACC_OTH_RD);

  // read data uses the pointer value from before this cycle's update
  always_comb begin
    unique case (kind)
      ACC_PTR_RD: rdata_d = DW'(ptr_q);
      ACC_DAT_RD: rdata_d = mem_rdata;
      default:    rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rdata_q <= '0;
    else if (rd_hit) rdata_q <= rdata_d;
  end

  assign rdata_o = rdata_q;

endmodule

// File: rtl/ram_window_port_chk.sv
module ram_window_port_chk #(
  parameter int            AW      = 5,
  parameter int            DW      = 8,
  parameter int            PW      = 8,
  parameter logic [AW-1:0] PTR_OFS = 5'h10,
  parameter logic [AW-1:0] DAT_OFS = 5'h13
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cs_i,
  input logic          rd_i,
  input logic          wr_i,
  input logic [AW-1:0] addr_i,
  input logic [DW-1:0] wdata_i,
  input logic          burst_en_i,
  input logic [DW-1:0] rdata_o,
  input logic [PW-1:0] ptr_q
);

  // R1
  reset_state_chk: assert property (@(posedge clk_i) !rst_ni |=> (ptr_q == '0) || !rst_ni);

  // R2
  ptr_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && wr_i && addr_i == PTR_OFS) |=> ptr_q == $past(wdata_i[PW-1:0]));

  // R2
  ptr_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && rd_i && !wr_i && addr_i == PTR_OFS) |=> rdata_o == DW'($past(ptr_q)));

  // R4
  no_burst_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && (rd_i || wr_i) && addr_i == DAT_OFS && !burst_en_i) |=> $stable(ptr_q));

  // R5
  burst_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && (rd_i || wr_i) && addr_i == DAT_OFS && burst_en_i)
      |=> ptr_q == PW'($past(ptr_q) + 1'b1));

  // R6
  other_no_move_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && (rd_i || wr_i) && addr_i != DAT_OFS && addr_i != PTR_OFS) |=> $stable(ptr_q));

  // R6
  other_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && rd_i && !wr_i && addr_i != DAT_OFS && addr_i != PTR_OFS) |=> rdata_o == '0);

  // R8
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_i |=> $stable(ptr_q) && $stable(rdata_o));

  // R8
  dual_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && rd_i && wr_i) |=> $stable(rdata_o));

endmodule

bind ram_window_port ram_window_port_chk #(
  .AW      (AW),
  .DW      (DW),
  .PW      (PW),
  .PTR_OFS (PTR_OFS),
  .DAT_OFS (DAT_OFS)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cs_i       (cs_i),
  .rd_i       (rd_i),
  .wr_i       (wr_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .burst_en_i (burst_en_i),
  .rdata_o    (rdata_o),
  .ptr_q      (ptr_q)
);

// File: tb/ram_window_port_tb.sv
module ram_window_port_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs = 1'b0, rd = 1'b0, wr = 1'b0, burst = 1'b0;
  logic [4:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [7:0] m_mem [256];
  logic [7:0] m_ptr;
  logic [7:0] m_rdata;

  always #10 clk = ~clk;

  ram_window_port u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .cs_i       (cs),
    .rd_i       (rd),
    .wr_i       (wr),
    .addr_i     (addr),
    .wdata_i    (wdata),
    .burst_en_i (burst),
    .rdata_o    (rdata)
  );

  function automatic logic [7:0] exp_read(logic [4:0] a, logic [7:0] p, logic [7:0] d);
    if (a == 5'h10) return p;
    if (a == 5'h13) return d;
    return 8'h00;
  endfunction

  function automatic logic [7:0] exp_ptr(logic c, logic r, logic w, logic [4:0] a,
                                         logic [7:0] wd, logic b, logic [7:0] p);
    if (!c || !(r || w)) return p;
    if (w && a == 5'h10) return wd;
    if (a == 5'h13 && b) return p + 8'd1;
    return p;
  endfunction

  task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  // drive at negedge, commit at posedge, compare at next negedge
  task automatic access(logic c, logic r, logic w, logic [4:0] a, logic [7:0] wd,
                        logic b, string tag);
    cs = c; rd = r; wr = w; addr = a; wdata = wd; burst = b;
    @(posedge clk);
    if (c && w) begin
      if (a == 5'h13) m_mem[m_ptr] = wd;
    end else if (c && r) begin
      m_rdata = exp_read(a, m_ptr, m_mem[m_ptr]);
    end
    m_ptr = exp_ptr(c, r, w, a, wd, b, m_ptr);
    @(negedge clk);
    cs = 1'b0; rd = 1'b0; wr = 1'b0;
    check(tag, rdata, m_rdata);
  endtask

  task automatic peek_ptr(string tag);
    access(1'b1, 1'b1, 1'b0, 5'h10, 8'h00, 1'b0, tag);
    check(tag, rdata, m_ptr);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog got %h exp %h", 8'h00, 8'h01);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    m_ptr = 8'h00;
    m_rdata = 8'h00;
    repeat (3) @(negedge clk);
    check("R1 rdata in reset", rdata, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rdata after reset", rdata, 8'h00);
    peek_ptr("R1 pointer after reset");

    // fill the whole RAM through a burst, wrapping at the end (R5, R7)
    for (int i = 0; i < 256; i++)
      access(1'b1, 1'b0, 1'b1, 5'h13, 8'(i * 7 + 3), 1'b1, "R5 fill");
    peek_ptr("R7 wrap after full burst");

    // R3, R4: fixed location without burst
    access(1'b1, 1'b0, 1'b1, 5'h10, 8'h40, 1'b0, "R2 load");
    access(1'b1, 1'b0, 1'b1, 5'h13, 8'hA5, 1'b0, "R3 write");
    access(1'b1, 1'b1, 1'b0, 5'h13, 8'h00, 1'b0, "R3 read");
    check("R3 data", rdata, 8'hA5);
    access(1'b1, 1'b1, 1'b0, 5'h13, 8'h00, 1'b0, "R4 reread");
    peek_ptr("R4 pointer held");

    // R5: burst read returns pre-increment byte
    access(1'b1, 1'b1, 1'b0, 5'h13, 8'h00, 1'b1, "R5 burst read 40");
    check("R5 first byte", rdata, 8'hA5);
    access(1'b1, 1'b1, 1'b0, 5'h13, 8'h00, 1'b1, "R5 burst read 41");
    check("R5 second byte", rdata, 8'(8'h41 * 7 + 3));
    peek_ptr("R5 pointer after two");

    // R7: wrap on a single step from FFh
    access(1'b1, 1'b0, 1'b1, 5'h10, 8'hFF, 1'b0, "R2 load FF");
    access(1'b1, 1'b1, 1'b0, 5'h13, 8'h00, 1'b1, "R7 read FF");
    peek_ptr("R7 pointer 00");

    // R9: pointer load right after burst access
    access(1'b1, 1'b0, 1'b1, 5'h13, 8'h11, 1'b1, "R9 burst write");
    access(1'b1, 1'b0, 1'b1, 5'h10, 8'h80, 1'b1, "R9 load");
    peek_ptr("R9 pointer is loaded value");

    // R6: other offsets
    access(1'b1, 1'b0, 1'b1, 5'h11, 8'h33, 1'b1, "R6 other write");
    access(1'b1, 1'b1, 1'b0, 5'h1F, 8'h00, 1'b1, "R6 other read");
    check("R6 other read zero", rdata, 8'h00);
    peek_ptr("R6 pointer unmoved");
    access(1'b1, 1'b1, 1'b0, 5'h13, 8'h00, 1'b0, "R6 RAM untouched");

    // R8: deselected and dual strobes
    access(1'b0, 1'b0, 1'b1, 5'h13, 8'hEE, 1'b1, "R8 cs low write");
    access(1'b0, 1'b1, 1'b0, 5'h10, 8'h00, 1'b1, "R8 cs low read");
    peek_ptr("R8 pointer after cs low");
    access(1'b1, 1'b1, 1'b1, 5'h13, 8'h5A, 1'b0, "R8 dual strobe holds rdata");
    access(1'b1, 1'b1, 1'b0, 5'h13, 8'h00, 1'b0, "R8 dual strobe wrote");
    check("R8 written byte", rdata, 8'h5A);

    // random mix
    for (int k = 0; k < 4000; k++) begin
      int unsigned sel;
      logic [4:0] a;
      logic c, r, w, b;
      sel = $urandom_range(0, 9);
      a = (sel < 2) ? 5'h10 : (sel < 8) ? 5'h13 : 5'($urandom_range(0, 31));
      c = ($urandom_range(0, 15) != 0);
      w = $urandom_range(0, 1);
      r = !w || ($urandom_range(0, 7) == 0);
      b = $urandom_range(0, 1);
      access(c, r, w, a, 8'($urandom), b,
             !c ? "R8 random" : (a == 5'h10) ? "R2 random" :
             (a != 5'h13) ? "R6 random" : b ? "R5 random" : "R3 random");
      if ((k % 16) == 0) peek_ptr("R4 random pointer");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule